// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block lets a controller reach 16-bit registers inside a PHY that are not memory-mapped. The PHY offers only a 32-bit control word and a 32-bit status word. The control word carries an address or data field plus four strobes. The status word carries read data plus an acknowledge. The sequencer turns one read or write request into the fixed series of control words the PHY expects. After every strobe edge it waits for the acknowledge to reach the matching level before it moves on. It returns the read data, or reports a timeout when an acknowledge never arrives.

Requests use a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a caller holding `req_valid` is held off for the whole access and must keep its fields stable until the transfer happens. Responses have no back-pressure. `rsp_valid` is a one-cycle pulse that the caller must take when it appears.

Each acknowledge wait samples the status word up to `MAX_POLLS` times, `POLL_GAP` clock cycles apart. The first sample is taken in the first cycle the new control word is driven.

Top module: `phy_reg_seq`

## Requirements
- R1: After reset, `ctrl_word` is zero, `req_ready` is high and `rsp_valid` is low.
- R2: Control word layout: bits 15:0 hold the address or data, bit 16 strobes address capture, bit 17 strobes data capture, bit 18 strobes write, bit 19 strobes read, and all other bits are zero. At most one strobe is high at a time. Status word layout: bits 15:0 hold read data and bit 16 is the acknowledge.
- R3: Every access starts with an address phase. The sequencer drives the address alone for one cycle, then the address with bit 16 until the acknowledge is 1, then the address alone until the acknowledge is 0.
- R4: A write then drives the data alone for one cycle, then the data with bit 17 until the acknowledge is 1, and then the data alone until it is 0. Next it drives bit 18 alone until the acknowledge is 1, and the data alone until it is 0. Finally it drives zero for one cycle before responding.
- R5: A read, after the address phase, drives bit 19 alone until the acknowledge is 1. On that sample it captures status bits 15:0. It then drives zero until the acknowledge is 0, and returns the captured value on `rsp_rdata` with the response.
- R6: Each wait samples the acknowledge in its first cycle, then every `POLL_GAP` cycles, for at most `MAX_POLLS` samples. A match on the last sample still counts as success.
- R7: If no sample matches, the wait times out. `ctrl_word` becomes zero in the same cycle that `rsp_valid` and `rsp_err` are both high. This applies to a wait for 1 and to a wait for 0.
- R8: A request is accepted only in idle. `req_ready` is low from the cycle after acceptance until the response cycle. A request presented while busy has no effect on the control words or on PHY state.
- R9: Each accepted request yields exactly one `rsp_valid` pulse of one cycle, with `rsp_err` low on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DATA_W | PHY register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Acknowledge timeout, valid with rsp_valid |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid on a read |
| ctrl_word | output | CTRL_W | Control word to the PHY |
| stat_word | input | CTRL_W | Status word from the PHY |

## Verification
The time to the response can be worked out exactly for any acknowledge delay. A wait whose acknowledge appears D cycles after the control word changes lasts ceil((D-1)/POLL_GAP)·POLL_GAP+1 cycles. A step with no wait lasts one cycle, and the response pulse follows the last step by one cycle. This gives 10 cycles for a write and 6 for a read at D=1. A rise timeout responds 9·POLL_GAP+3 cycles after acceptance. The bench's PHY model toggles its acknowledge on the falling edge after a set delay, and all checks sample on falling edges. It counts cycles from the acceptance edge, so each latency, strobe duration and control-word trace is compared against these formulas at the cycle where the value is due.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [3:0] {
    STP_ADR_SET  = 4'd0,
    STP_ADR_CAP  = 4'd1,
    STP_ADR_REL  = 4'd2,
    STP_DAT_SET  = 4'd3,
    STP_DAT_CAP  = 4'd4,
    STP_DAT_REL  = 4'd5,
    STP_WR_PULSE = 4'd6,
    STP_WR_REL   = 4'd7,
    STP_WR_CLR   = 4'd8,
    STP_RD_PULSE = 4'd9,
    STP_RD_CLR   = 4'd10
  } step_t;

  typedef struct packed {
    logic waits;
    logic level;
    logic last;
    logic grab;
  } step_info_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/phy_ack_poller.sv
module phy_ack_poller #(
  parameter int MAX_POLLS = 10,
  parameter int POLL_GAP  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic ack,
  input  logic level,
  output logic hit,
  output logic miss
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(POLL_GAP + 1);

  logic [PW-1:0] polls;
  logic [GW-1:0] gap;
  logic          match;
  logic          sample_now;
  logic          last_poll;

  assign match      = (ack == level);
  assign sample_now = active && (gap == '0);
  assign last_poll  = (polls == PW'(MAX_POLLS - 1));
  assign hit        = sample_now && match;
  assign miss       = sample_now && !match && last_poll;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      polls <= '0;
      gap   <= '0;
    end else if (active) begin
      if (gap != '0) begin
        gap <= gap - 1'b1;
      end else if (!match && !last_poll) begin
        polls <= polls + 1'b1;
        gap   <= GW'(POLL_GAP - 1);
      end
    end
  end

  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    polls < PW'(MAX_POLLS));

  p_gap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap < GW'(POLL_GAP));

  p_restart_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (polls == '0 && gap == '0));

endmodule

// File: rtl/phy_step_decode.sv
module phy_step_decode
  import phy_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 32
) (
  input  step_t               step,
  input  logic                is_write,
  input  logic [DATA_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output step_info_t          info,
  output step_t               nxt,
  output logic [CTRL_W-1:0]   nxt_word
);
  localparam int CAP_A_BIT = DATA_W;
  localparam int CAP_D_BIT = DATA_W + 1;
  localparam int WR_BIT    = DATA_W + 2;
  localparam int RD_BIT    = DATA_W + 3;

  function automatic logic [CTRL_W-1:0] word_of(step_t s, logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] d);
    logic [CTRL_W-1:0] w;
    w = '0;
    case (s)
      STP_ADR_SET, STP_ADR_REL: w[DATA_W-1:0] = a;
      STP_ADR_CAP: begin
        w[DATA_W-1:0] = a;
        w[CAP_A_BIT]  = 1'b1;
      end
      STP_DAT_SET, STP_DAT_REL, STP_WR_REL: w[DATA_W-1:0] = d;
      STP_DAT_CAP: begin
        w[DATA_W-1:0] = d;
        w[CAP_D_BIT]  = 1'b1;
      end
      STP_WR_PULSE: w[WR_BIT] = 1'b1;
      STP_RD_PULSE: w[RD_BIT] = 1'b1;
      default:      w = '0;
    endcase
    return w;
  endfunction

  always_comb begin
    info = '0;
    case (step)
      STP_ADR_CAP, STP_DAT_CAP, STP_WR_PULSE: begin
        info.waits = 1'b1;
        info.level = 1'b1;
      end
      STP_ADR_REL, STP_DAT_REL, STP_WR_REL: begin
        info.waits = 1'b1;
        info.level = 1'b0;
      end
      STP_RD_PULSE: begin
        info.waits = 1'b1;
        info.level = 1'b1;
        info.grab  = 1'b1;
      end
      STP_RD_CLR: begin
        info.waits = 1'b1;
        info.level = 1'b0;
        info.last  = 1'b1;
      end
      STP_WR_CLR: info.last = 1'b1;
      default:    info = '0;
    endcase
  end

  always_comb begin
    case (step)
      STP_ADR_SET:  nxt = STP_ADR_CAP;
      STP_ADR_CAP:  nxt = STP_ADR_REL;
      STP_ADR_REL:  nxt = is_write ? STP_DAT_SET : STP_RD_PULSE;
      STP_DAT_SET:  nxt = STP_DAT_CAP;
      STP_DAT_CAP:  nxt = STP_DAT_REL;
      STP_DAT_REL:  nxt = STP_WR_PULSE;
      STP_WR_PULSE: nxt = STP_WR_REL;
      STP_WR_REL:   nxt = STP_WR_CLR;
      STP_RD_PULSE: nxt = STP_RD_CLR;
      default:      nxt = STP_ADR_SET;
    endcase
  end

  assign nxt_word = word_of(nxt, addr, wdata);

endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq
  import phy_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CTRL_W    = 32,
  parameter int MAX_POLLS = 10,
  parameter int POLL_GAP  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [CTRL_W-1:0] ctrl_word,
  input  logic [CTRL_W-1:0] stat_word
);
  localparam int CAP_A_BIT = DATA_W;
  localparam int RD_BIT    = DATA_W + 3;
  localparam int ACK_BIT   = DATA_W;

  seq_state_t        state;
  step_t             step;
  step_t             step_nxt;
  step_info_t        info;
  logic [CTRL_W-1:0] word_nxt;
  logic [CTRL_W-1:0] ctrl_q;
  logic              op_write;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              err_q;

  logic running, accept, step_ok, finish, go_next, fail;
  logic poll_hit, poll_miss, poll_active, poll_restart;
  logic stat_unused;

  assign stat_unused = ^stat_word[CTRL_W-1:ACK_BIT+1];

  assign running      = (state == SEQ_RUN);
  assign accept       = !running && req_valid;
  assign poll_active  = running && info.waits;
  assign step_ok      = running && (!info.waits || poll_hit);
  assign finish       = step_ok && info.last;
  assign go_next      = step_ok && !info.last;
  assign fail         = poll_active && poll_miss;
  assign poll_restart = go_next || !running;

  phy_step_decode #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
  ) u_decode (
    .step     (step),
    .is_write (op_write),
    .addr     (addr_q),
    .wdata    (data_q),
    .info     (info),
    .nxt      (step_nxt),
    .nxt_word (word_nxt)
  );

  phy_ack_poller #(
    .MAX_POLLS (MAX_POLLS),
    .POLL_GAP  (POLL_GAP)
  ) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (poll_restart),
    .active  (poll_active),
    .ack     (stat_word[ACK_BIT]),
    .level   (info.level),
    .hit     (poll_hit),
    .miss    (poll_miss)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      step     <= STP_ADR_SET;
      ctrl_q   <= '0;
      op_write <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        state    <= SEQ_RUN;
        step     <= STP_ADR_SET;
        op_write <= req_write;
        addr_q   <= req_addr;
        data_q   <= req_wdata;
        rdata_q  <= '0;
        ctrl_q   <= CTRL_W'(req_addr);
      end else if (fail) begin
        state  <= SEQ_IDLE;
        ctrl_q <= '0;
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end else if (finish) begin
        state  <= SEQ_IDLE;
        ctrl_q <= '0;
        done_q <= 1'b1;
      end else if (go_next) begin
        step   <= step_nxt;
        ctrl_q <= word_nxt;
      end
      if (running && info.grab && poll_hit) begin
        rdata_q <= stat_word[DATA_W-1:0];
      end
    end
  end

  assign req_ready = !running;
  assign rsp_valid = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign ctrl_word = ctrl_q;

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_word[RD_BIT:CAP_A_BIT]));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[CTRL_W-1:RD_BIT+1] == '0);

  p_busy_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word != '0) |-> !req_ready);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  p_err_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (ctrl_word == '0 && req_ready));

endmodule

// File: tb/phy_reg_seq_test.sv
module phy_reg_seq_test;
  localparam int GAP   = 100;
  localparam int POLLS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [15:0] rsp_rdata;
  logic [31:0] ctrl_word;
  logic [31:0] stat_word;

  always #5 clk = ~clk;

  phy_reg_seq #(
    .DATA_W(16), .CTRL_W(32), .MAX_POLLS(POLLS), .POLL_GAP(GAP)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ctrl_word(ctrl_word), .stat_word(stat_word)
  );

  int errs = 0;
  int checks = 0;

  // PHY model: 0 normal, 1 never acknowledges, 2 acknowledge sticks high
  int          rmode = 0;
  int          rdly  = 1;
  int          rcnt  = 0;
  logic        ack   = 1'b0;
  logic [15:0] sdata = '0;
  logic [2:0]  raddr = '0;
  logic [15:0] rdat  = '0;
  logic [15:0] mem [0:7];

  assign stat_word = {15'b0, ack, sdata};

  always @(negedge clk) begin
    logic want;
    want = |ctrl_word[19:16];
    if (rmode == 1 && !ack) want = 1'b0;
    if (rmode == 2 && ack)  want = 1'b1;
    if (want != ack) begin
      if (rcnt + 1 >= rdly) begin
        ack  = want;
        rcnt = 0;
        if (want) begin
          if (ctrl_word[16]) raddr = ctrl_word[2:0];
          if (ctrl_word[17]) rdat  = ctrl_word[15:0];
          if (ctrl_word[18]) mem[raddr] = rdat;
          if (ctrl_word[19]) sdata = mem[raddr];
        end
      end else begin
        rcnt = rcnt + 1;
      end
    end else begin
      rcnt = 0;
    end
  end

  // control word trace
  logic [31:0] trace [0:15];
  int          tn = 0;
  logic [31:0] prev_ctrl = '0;
  int          strobe_cnt = 0;
  bit          rec = 1'b0;

  always @(negedge clk) begin
    if (rec) begin
      if (ctrl_word != prev_ctrl) begin
        if (tn < 16) trace[tn] = ctrl_word;
        tn = tn + 1;
        prev_ctrl = ctrl_word;
      end
      if (ctrl_word[16]) strobe_cnt = strobe_cnt + 1;
    end
  end

  logic [31:0] exp_tr [0:15];
  int          exp_n;

  int          lat;
  int          ready_hi;
  bit          got_err;
  logic [15:0] got_rdata;
  logic [31:0] ctrl_at_rsp;
  bit          pulse_ok;

  task automatic chk(input string req, input bit ok, input longint act, input longint expv);
    checks = checks + 1;
    if (!ok) begin
      errs = errs + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic chk_trace(input string req);
    bit ok;
    ok = (tn == exp_n);
    for (int i = 0; i < 16; i++) begin
      if (ok && i < exp_n && trace[i] != exp_tr[i]) begin
        ok = 1'b0;
        $display("FAIL %s: trace[%0d] actual=0x%0h expected=0x%0h", req, i, trace[i], exp_tr[i]);
        errs = errs + 1;
      end
    end
    checks = checks + 1;
    if (tn != exp_n) begin
      errs = errs + 1;
      $display("FAIL %s: trace length actual=%0d expected=%0d", req, tn, exp_n);
    end
  endtask

  function automatic int wait_len(input int d);
    return ((d - 1 + GAP - 1) / GAP) * GAP + 1;
  endfunction

  task automatic set_write_trace(input logic [15:0] a, input logic [15:0] d);
    exp_tr[0] = {16'h0, a};
    exp_tr[1] = {16'h1, a};
    exp_tr[2] = {16'h0, a};
    exp_tr[3] = {16'h0, d};
    exp_tr[4] = {16'h2, d};
    exp_tr[5] = {16'h0, d};
    exp_tr[6] = 32'h0004_0000;
    exp_tr[7] = {16'h0, d};
    exp_tr[8] = 32'h0;
    exp_n = 9;
  endtask

  task automatic set_read_trace(input logic [15:0] a);
    exp_tr[0] = {16'h0, a};
    exp_tr[1] = {16'h1, a};
    exp_tr[2] = {16'h0, a};
    exp_tr[3] = 32'h0008_0000;
    exp_tr[4] = 32'h0;
    exp_n = 5;
  endtask

  task automatic do_req(input bit w, input logic [15:0] a, input logic [15:0] d, input int busy);
    @(negedge clk);
    tn = 0; prev_ctrl = ctrl_word; strobe_cnt = 0; rec = 1'b1; ready_hi = 0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    lat = 1;
    while (!rsp_valid && lat < 20000) begin
      if (req_ready) ready_hi = ready_hi + 1;
      if (lat < busy) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0005; req_wdata = 16'h7777;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      lat = lat + 1;
    end
    req_valid = 1'b0;
    got_err = rsp_err;
    got_rdata = rsp_rdata;
    ctrl_at_rsp = ctrl_word;
    @(negedge clk);
    pulse_ok = !rsp_valid;
    rec = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctrl_word zero after reset", ctrl_word == 32'h0, ctrl_word, 0);
    chk("R1 ready high after reset", req_ready == 1'b1, req_ready, 1);
    chk("R1 no response after reset", rsp_valid == 1'b0, rsp_valid, 0);
  endtask

  task automatic t_write_fast;
    rmode = 0; rdly = 1;
    do_req(1'b1, 16'h0012, 16'hA5C3, 0);
    set_write_trace(16'h0012, 16'hA5C3);
    chk_trace("R4 write control sequence");
    chk("R4 write latency D=1", lat == 10, lat, 10);
    chk("R9 write err low", got_err == 1'b0, got_err, 0);
    chk("R9 single pulse", pulse_ok, pulse_ok, 1);
    chk("R8 ready low while busy", ready_hi == 0, ready_hi, 0);
  endtask

  task automatic t_read_fast;
    rmode = 0; rdly = 1;
    do_req(1'b0, 16'h0012, 16'h0000, 0);
    set_read_trace(16'h0012);
    chk_trace("R3 R5 read control sequence");
    chk("R5 read back written value", got_rdata == 16'hA5C3, got_rdata, 16'hA5C3);
    chk("R5 read latency D=1", lat == 6, lat, 6);
    chk("R2 status data field", got_err == 1'b0, got_err, 0);
  endtask

  task automatic t_slow_acks;
    int w;
    rmode = 0; rdly = 2;
    w = wait_len(2);
    do_req(1'b1, 16'h0033, 16'h1357, 0);
    chk("R6 write latency with retries", lat == 3 + 6 * w + 1, lat, 3 + 6 * w + 1);
    do_req(1'b0, 16'h0033, 16'h0, 0);
    chk("R6 read latency with retries", lat == 1 + 4 * w + 1, lat, 1 + 4 * w + 1);
    chk("R5 read after slow write", got_rdata == 16'h1357, got_rdata, 16'h1357);
  endtask

  task automatic t_preset_read;
    rmode = 0; rdly = 1;
    do_req(1'b0, 16'h0007, 16'h0, 0);
    chk("R5 read preset register", got_rdata == 16'hBEEF, got_rdata, 16'hBEEF);
  endtask

  task automatic t_last_sample;
    int d;
    d = (POLLS - 1) * GAP + 1;
    rmode = 0; rdly = d;
    do_req(1'b0, 16'h0007, 16'h0, 0);
    chk("R6 ack on last sample succeeds", got_err == 1'b0, got_err, 0);
    chk("R6 last-sample latency", lat == 1 + 4 * d + 1, lat, 1 + 4 * d + 1);
    chk("R5 data on last-sample read", got_rdata == 16'hBEEF, got_rdata, 16'hBEEF);
  endtask

  task automatic t_late_timeout;
    rmode = 0; rdly = (POLLS - 1) * GAP + 2;
    do_req(1'b1, 16'h0004, 16'h2222, 0);
    chk("R7 late ack times out", got_err == 1'b1, got_err, 1);
    chk("R7 timeout latency", lat == (POLLS - 1) * GAP + 3, lat, (POLLS - 1) * GAP + 3);
    chk("R6 strobe held for full window", strobe_cnt == (POLLS - 1) * GAP + 1,
        strobe_cnt, (POLLS - 1) * GAP + 1);
    chk("R7 ctrl zero at error response", ctrl_at_rsp == 32'h0, ctrl_at_rsp, 0);
    exp_tr[0] = 32'h0000_0004; exp_tr[1] = 32'h0001_0004; exp_tr[2] = 32'h0; exp_n = 3;
    chk_trace("R7 rise timeout trace");
    rmode = 0; rdly = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_dead_timeout;
    rmode = 1; rdly = 1;
    do_req(1'b0, 16'h0006, 16'h0, 0);
    chk("R7 dead PHY read error", got_err == 1'b1, got_err, 1);
    chk("R9 error response single pulse", pulse_ok, pulse_ok, 1);
    rmode = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_stuck_timeout;
    rmode = 2; rdly = 1;
    do_req(1'b1, 16'h0006, 16'h4444, 0);
    chk("R7 stuck ack fall timeout", got_err == 1'b1, got_err, 1);
    chk("R7 fall timeout latency", lat == 2 + (POLLS - 1) * GAP + 2, lat, 2 + (POLLS - 1) * GAP + 2);
    exp_tr[0] = 32'h0000_0006; exp_tr[1] = 32'h0001_0006; exp_tr[2] = 32'h0000_0006;
    exp_tr[3] = 32'h0; exp_n = 4;
    chk_trace("R3 R7 fall timeout trace");
    rmode = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_busy_ignored;
    rmode = 0; rdly = 2;
    do_req(1'b1, 16'h0001, 16'h0F0F, 60);
    set_write_trace(16'h0001, 16'h0F0F);
    chk_trace("R8 busy request leaves sequence unchanged");
    chk("R8 ready low during busy request", ready_hi == 0, ready_hi, 0);
    rdly = 1;
    do_req(1'b0, 16'h0005, 16'h0, 0);
    chk("R8 busy request did not write PHY", got_rdata == 16'h5555, got_rdata, 16'h5555);
    do_req(1'b0, 16'h0001, 16'h0, 0);
    chk("R4 accepted write landed", got_rdata == 16'h0F0F, got_rdata, 16'h0F0F);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 16'h0;
    mem[5] = 16'h5555;
    mem[7] = 16'hBEEF;
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write_fast;
    t_read_fast;
    t_slow_acks;
    t_preset_read;
    t_last_sample;
    t_late_timeout;
    t_dead_timeout;
    t_stuck_timeout;
    t_busy_ignored;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks = checks + 1;
      errs = errs + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule